// File: doc/BRIEF.md
# Direct Digital Synthesizer with Two-Word Frequency Shift Keying

This block generates a quadrature pair of digital sine and cosine samples whose frequency is set by a tuning word. A wide phase accumulator advances by the tuning word on every enabled clock and wraps modulo its full range. As a result, the output frequency is the clock rate times the tuning word divided by two to the power of the accumulator width. The upper bits of the accumulator form a coarse phase address. A quarter-wave amplitude table, folded by the two top address bits, turns that address into signed samples.

Two tuning words are presented at the inputs, and a one-bit keying input picks the one that is added in each cycle. The keying input can change in any cycle. The accumulator is never cleared on a switch, so the generated waveform stays phase-continuous while its frequency jumps. The samples are meant for a downstream converter and its reconstruction filter. The full accumulator value is also brought out for phase monitoring.

Top module: `dds_fsk_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator, `phase_out`, `sin_out` and `cos_out` all become zero.
- R2: On every rising edge with `enable` high and reset released, the accumulator value seen on `phase_out` becomes its previous value plus the selected tuning word, modulo 2^ACC_W.
- R3: When `fsk_sel` is 0, `tune_a` is the word added, and when it is 1, `tune_b` is added. The selection applies in the same cycle it is sampled. A switch neither clears nor disturbs the accumulated phase.
- R4: On a rising edge with `enable` low, the accumulator keeps its value.
- R5: The phase address is the top PHASE_W bits of the accumulator. With a 5-bit address slice and a word whose top-5-bit value is 5 (and zero low bits), successive addresses run 5, 10, 15, 20, 25, 30, 3, 8 after starting from 0.
- R6: `sin_out` is two's complement and equals round(A·sin(2π·a/2^PHASE_W)) within 1 LSB, where A = 2^(AMP_W-1)-1 and a is the phase address.
- R7: `cos_out` equals the sine value at address a + 2^(PHASE_W-2) modulo 2^PHASE_W, within 1 LSB. At a = 0 it is exactly +A.
- R8: `sin_out` is exactly +A at a = 2^(PHASE_W-2), and neither output ever takes the most negative code -2^(AMP_W-1).
- R9: Both sample outputs are registered and reflect the phase address that `phase_out` showed one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | High to advance the accumulator; low to hold it |
| fsk_sel | input | 1 | Keying bit: 0 adds `tune_a`, 1 adds `tune_b` |
| tune_a | input | ACC_W | Tuning word used when `fsk_sel` is 0 |
| tune_b | input | ACC_W | Tuning word used when `fsk_sel` is 1 |
| sin_out | output | AMP_W | Signed sine sample |
| cos_out | output | AMP_W | Signed cosine sample |
| phase_out | output | ACC_W | Current accumulator value |

## Verification
The bench builds the block with a 12-bit accumulator, an 8-bit phase address and 10-bit samples. At these sizes every one of the 256 phase addresses can be stepped through in a few hundred cycles, and each sine and cosine sample is compared with a value computed directly from the full-circle sine. The short accumulator wraps within a handful of cycles, so runs that toggle the keying bit on every clock cross the wrap point many times and exercise phase continuity there. Scaling the example tuning word into the top five bits reproduces the 5-bit wrap sequence exactly.

// File: rtl/dds_pkg.sv
// Package: shared helpers for the synthesizer.
// Assumes: called only at elaboration to build constant tables.
package dds_pkg;

    // Rounded magnitude of A*sin(2*pi*k/2^phase_w), A = 2^(amp_w-1)-1, for 0 <= k <= quarter turn.
    function automatic int quarter_mag(input int k, input int phase_w, input int amp_w);
        real full;
        real ang;
        full = real'((1 << (amp_w - 1)) - 1);
        ang  = 2.0 * 3.14159265358979323846 * real'(k) / real'(1 << phase_w);
        return $rtoi(full * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
// Module: phase accumulator with two selectable increments.
// Adds tune_a or tune_b (picked by fsk_sel) each enabled cycle, modulo 2^ACC_W.
// Assumes: synchronous active-low reset; the accumulator is never cleared on a switch.
module dds_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fsk_sel,
    input  logic [ACC_W-1:0] tune_a,
    input  logic [ACC_W-1:0] tune_b,
    output logic [ACC_W-1:0] acc_q
);

    logic [ACC_W-1:0] step_w;

    // Pick the increment for this cycle.
    always_comb begin
        step_w = fsk_sel ? tune_b : tune_a;
    end

    // Advance, hold or clear the accumulated phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (enable) begin
            acc_q <= acc_q + step_w;
        end
    end

    // R4
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(acc_q));

endmodule

// File: rtl/dds_quarter_rom.sv
// Module: quarter-wave sine magnitude table.
// Entries 0..2^(PHASE_W-2) hold rounded sine magnitudes; higher addresses read zero.
// Assumes: PHASE_W >= 3; the table is computed at elaboration.
module dds_quarter_rom #(
    parameter int PHASE_W = 10,
    parameter int AMP_W   = 12
) (
    input  logic [PHASE_W-2:0] addr,
    output logic [AMP_W-2:0]   mag
);

    localparam int DEPTH   = 1 << (PHASE_W - 1);
    localparam int QUARTER = 1 << (PHASE_W - 2);

    logic [AMP_W-2:0] table_w [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam int VAL = (k <= QUARTER) ? dds_pkg::quarter_mag(k, PHASE_W, AMP_W) : 0;
        assign table_w[k] = (AMP_W - 1)'(VAL);
    end

    // Read the addressed magnitude.
    always_comb begin
        mag = table_w[addr];
    end

endmodule

// File: rtl/dds_fold.sv
// Module: folds a full-circle phase address onto the quarter-wave table.
// Quadrant bit 0 mirrors the table index; quadrant bit 1 negates the magnitude.
// Assumes: PHASE_W >= 3; output is two's complement and combinational.
module dds_fold #(
    parameter int PHASE_W = 10,
    parameter int AMP_W   = 12
) (
    input  logic [PHASE_W-1:0]      phase,
    output logic signed [AMP_W-1:0] sample
);

    localparam logic [PHASE_W-2:0] QTR = (PHASE_W - 1)'(1 << (PHASE_W - 2));

    logic [1:0]         quad_w;
    logic [PHASE_W-2:0] idx_w;
    logic [PHASE_W-2:0] addr_w;
    logic [AMP_W-2:0]   mag_w;

    // Split the address and mirror the index in odd quadrants.
    always_comb begin
        quad_w = phase[PHASE_W-1 -: 2];
        idx_w  = {1'b0, phase[PHASE_W-3:0]};
        addr_w = quad_w[0] ? (QTR - idx_w) : idx_w;
    end

    dds_quarter_rom #(
        .PHASE_W(PHASE_W),
        .AMP_W  (AMP_W)
    ) rom_i (
        .addr(addr_w),
        .mag (mag_w)
    );

    // Apply the sign of the lower half-circle.
    always_comb begin
        sample = quad_w[1] ? -$signed({1'b0, mag_w}) : $signed({1'b0, mag_w});
    end

endmodule

// File: rtl/dds_fsk_core.sv
// Module: direct digital synthesizer with two-word phase-continuous keying.
// Accumulator top PHASE_W bits address a folded sine table for sine and,
// offset by a quarter turn, for cosine. Samples are registered one cycle after the phase.
// Assumes: synchronous active-low reset; PHASE_W >= 3 and PHASE_W <= ACC_W.
module dds_fsk_core #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 10,
    parameter int AMP_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    fsk_sel,
    input  logic [ACC_W-1:0]        tune_a,
    input  logic [ACC_W-1:0]        tune_b,
    output logic signed [AMP_W-1:0] sin_out,
    output logic signed [AMP_W-1:0] cos_out,
    output logic [ACC_W-1:0]        phase_out
);

    localparam logic [PHASE_W-1:0]      QTR_P   = PHASE_W'(1 << (PHASE_W - 2));
    localparam logic signed [AMP_W-1:0] AMP_MAX = AMP_W'((1 << (AMP_W - 1)) - 1);
    localparam logic signed [AMP_W-1:0] AMP_MIN = AMP_W'(1 << (AMP_W - 1));

    logic [ACC_W-1:0]        acc_w;
    logic [PHASE_W-1:0]      chan_phase [2];
    logic signed [AMP_W-1:0] chan_smp   [2];

    dds_phase_acc #(
        .ACC_W(ACC_W)
    ) acc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .fsk_sel(fsk_sel),
        .tune_a (tune_a),
        .tune_b (tune_b),
        .acc_q  (acc_w)
    );

    // Derive per-channel phase: channel 0 is sine, channel 1 leads by a quarter turn.
    always_comb begin
        chan_phase[0] = acc_w[ACC_W-1 -: PHASE_W];
        chan_phase[1] = acc_w[ACC_W-1 -: PHASE_W] + QTR_P;
    end

    for (genvar c = 0; c < 2; c++) begin : g_chan
        dds_fold #(
            .PHASE_W(PHASE_W),
            .AMP_W  (AMP_W)
        ) fold_i (
            .phase (chan_phase[c]),
            .sample(chan_smp[c])
        );
    end

    // Register the samples one cycle behind the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_out <= '0;
            cos_out <= '0;
        end else begin
            sin_out <= chan_smp[0];
            cos_out <= chan_smp[1];
        end
    end

    assign phase_out = acc_w;

    // R2 R3
    acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> phase_out == $past(phase_out) + $past(fsk_sel ? tune_b : tune_a));

    // R8
    sin_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_out[ACC_W-1 -: PHASE_W]) == QTR_P) |-> sin_out == AMP_MAX);

    // R7
    cos_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_out[ACC_W-1 -: PHASE_W]) == '0) |-> cos_out == AMP_MAX);

    // R8
    no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sin_out != AMP_MIN && cos_out != AMP_MIN);

endmodule

// File: tb/dds_fsk_core_tb_top.sv
`timescale 1ns/1ps
module dds_fsk_core_tb_top;

    localparam int N = 12;
    localparam int P = 8;
    localparam int D = 10;
    localparam int Q = 1 << (P - 2);
    localparam int AMAX = (1 << (D - 1)) - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                enable = 1'b0;
    logic                fsk_sel = 1'b0;
    logic [N-1:0]        tune_a = '0;
    logic [N-1:0]        tune_b = '0;
    logic signed [D-1:0] sin_out;
    logic signed [D-1:0] cos_out;
    logic [N-1:0]        phase_out;

    int           n_chk = 0;
    int           n_fail = 0;
    logic [N-1:0] m_acc = '0;
    logic [N-1:0] m_prev = '0;

    always #2.5 clk = ~clk;

    dds_fsk_core #(.ACC_W(N), .PHASE_W(P), .AMP_W(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fsk_sel(fsk_sel),
        .tune_a(tune_a), .tune_b(tune_b),
        .sin_out(sin_out), .cos_out(cos_out), .phase_out(phase_out)
    );

    function automatic int exp_sin(input int a);
        real x;
        x = real'(AMAX) * $sin(2.0 * 3.14159265358979323846 * real'(a) / real'(1 << P));
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic near(input string req, input int act, input int expv);
        check((act - expv <= 1) && (expv - act <= 1), req, act, expv);
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic step();
        int a;
        @(posedge clk);
        m_prev = m_acc;
        if (enable) m_acc = m_acc + (fsk_sel ? tune_b : tune_a);
        @(negedge clk);
        a = int'(m_prev[N-1 -: P]);
        check(phase_out == m_acc, "R2/R3 phase", int'(phase_out), int'(m_acc));
        near("R6/R9 sine", int'(sin_out), exp_sin(a));
        near("R7/R9 cosine", int'(cos_out), exp_sin((a + Q) % (1 << P)));
        if (a == Q) check(int'(sin_out) == AMAX, "R8 sine peak", int'(sin_out), AMAX);
        if (a == 0) check(int'(cos_out) == AMAX, "R7 cosine peak", int'(cos_out), AMAX);
        check(int'(sin_out) != -AMAX - 1 && int'(cos_out) != -AMAX - 1, "R8 min code",
              int'(sin_out), -AMAX);
    endtask

    initial begin
        logic [N-1:0] held;
        logic [15:0]  lfsr;
        lfsr = 16'hACE1;
        // R1: reset state
        tune_a = 12'h123;
        enable = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(phase_out == '0, "R1 phase", int'(phase_out), 0);
        check(sin_out == '0, "R1 sine", int'(sin_out), 0);
        check(cos_out == '0, "R1 cosine", int'(cos_out), 0);
        rst_n = 1'b1;
        enable = 1'b0;
        m_acc = '0;

        // R5: 5-bit slice wrap sequence
        tune_a = N'(5 << (N - 5));
        fsk_sel = 1'b0;
        enable = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            step();
            check(int'(phase_out[N-1 -: 5]) == (5 * i) % 32, "R5 sequence",
                  int'(phase_out[N-1 -: 5]), (5 * i) % 32);
        end

        // R4: enable low holds the phase
        tune_a = 12'h3A7;
        tune_b = 12'h0F1;
        enable = 1'b0;
        held = phase_out;
        for (int i = 0; i < 6; i++) begin
            fsk_sel = i[0];
            step();
            check(phase_out == held, "R4 hold", int'(phase_out), int'(held));
        end

        // R6 R7: sweep every phase address in both directions
        enable = 1'b1;
        fsk_sel = 1'b0;
        tune_a = N'(1 << (N - P));
        tune_b = N'(-(1 << (N - P)));
        for (int i = 0; i < (1 << P) + 4; i++) step();
        fsk_sel = 1'b1;
        for (int i = 0; i < (1 << P) + 4; i++) step();

        // R3: toggle the keying bit every cycle; phase must stay continuous
        tune_a = 12'h1B5;
        tune_b = 12'hE29;
        for (int i = 0; i < 200; i++) begin
            fsk_sel = ~fsk_sel;
            step();
        end

        // R2 R3 R4: pseudo-random words, keying and enable
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0) tune_a = lfsr[N-1:0];
            if (lfsr[7:4] == 4'h5) tune_b = {lfsr[3:0], lfsr[15:8]};
            fsk_sel = lfsr[9];
            enable = (lfsr[12:11] != 2'b00);
            step();
        end

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(phase_out == '0 && sin_out == '0 && cos_out == '0, "R1 mid-run reset",
              int'(phase_out), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule